// File: doc/BRIEF.md
# Paged External Data Memory Access Controller

This block connects a simple core-side request port to an asynchronous external byte-wide data memory. The core asks for a single-byte read or write and chooses one of two addressing modes. In pointer mode the 24-bit address comes from three software-loaded registers: a page register, a pointer-high register and a pointer-low register. In indirect mode the low address byte comes from an 8-bit register value that the core supplies with the request. An extension register supplies the middle byte in this mode. The top byte is either zero or the page register, as a control bit selects.

Each access drives one active-high strobe. A read uses the read strobe and a write uses the write strobe. The strobe stays active for 1 to 8 clocks, set by a 3-bit stretch register that is sampled when the access starts. While the write strobe is active, the block enables the tri-state drivers of the external data bus. At the end of a read, the block captures the byte from the bus. In the cycle after the strobe ends, the block raises a one-cycle done pulse, and the captured byte is presented to the core at that time. The page, pointer, extension, stretch and control registers are loaded through a small register-write port.

Top module: `xmem_pager`

## Requirements
- R1: In pointer mode (`req_indirect`=0), the address during the strobe is {page, pointer-high, pointer-low} in bits 23:16, 15:8 and 7:0. Each byte takes the register value in force in the cycle the request is accepted.
- R2: In indirect mode (`req_indirect`=1), the address is {X, extension, `req_ireg`}. X is the page register when control bit 0 is 1, and zero when it is 0.
- R3: The strobe stays active for exactly stretch+1 consecutive clocks, where stretch is 0..7. It rises in the cycle after the request is accepted.
- R4: `mem_rd` is active only for reads and `mem_wr` only for writes. The two are never active together, and both are low when no access is in progress.
- R5: `mem_oe` is high exactly in the cycles in which `mem_wr` is high.
- R6: Read data is sampled in the last strobe cycle. `done` is high for exactly one cycle, the cycle after the strobe ends, and `rd_data` then holds the captured byte until the next read completes.
- R7: `mem_addr` and `mem_wdata` hold steady for the whole strobe. A register write during an access, including a write to stretch, does not change the access in progress.
- R8: A request that arrives while an access is in its strobe or done cycle is ignored. The block accepts requests only when idle.
- R9: Register-write encoding on `cfg_sel`:
  - 0 = page.
  - 1 = pointer-low.
  - 2 = pointer-high.
  - 3 = extension.
  - 4 = stretch, taken from `cfg_wdata[2:0]`.
  - 5 = control, taken from `cfg_wdata[0]`.
  - 6 and 7 are ignored.

  Reset clears all of these registers, both strobes, `mem_oe`, `done` and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 8 | Register write value |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_indirect | input | 1 | 1 = indirect mode, 0 = pointer mode |
| req_ireg | input | 8 | Indirect register value (low address byte) |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Captured read byte |
| mem_addr | output | 24 | External address |
| mem_wdata | output | 8 | External write data |
| mem_rdata | input | 8 | External read data |
| mem_rd | output | 1 | Read strobe, active high |
| mem_wr | output | 1 | Write strobe, active high |
| mem_oe | output | 1 | Data bus output enable |

## Verification
The bench targets both stretch extremes:
- With stretch 0, an off-by-one counter would either produce a zero-length strobe or stretch it to two clocks.
- With stretch 7, a three-bit count that wraps would produce a one-clock strobe.

It also targets writes to stretch and to the pointer while an access is in progress. A design that reads live register values would then change the strobe length or the address in the middle of the strobe.

In indirect mode the bench toggles the page-select bit. A design that confused the two modes would leak the page byte, or the pointer bytes, into the address.

Requests held during the strobe and done cycles test R8, because a design that accepted them would start a second strobe or corrupt the write data.

// File: rtl/xmp_pkg.sv
package xmp_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 3 * BYTE_W;
  localparam int STRETCH_W = 3;
  localparam int SEL_W     = 3;
  localparam int NUM_REGS  = 6;

  localparam logic [SEL_W-1:0] SEL_PAGE    = 3'd0;
  localparam logic [SEL_W-1:0] SEL_PTR_LO  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_PTR_HI  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_EXT     = 3'd3;
  localparam logic [SEL_W-1:0] SEL_STRETCH = 3'd4;
  localparam logic [SEL_W-1:0] SEL_CTRL    = 3'd5;

  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,
    XS_STROBE = 2'd1,
    XS_DONE   = 2'd2
  } xs_state_t;

  typedef struct packed {
    logic [BYTE_W-1:0]    page;
    logic [BYTE_W-1:0]    ptr_hi;
    logic [BYTE_W-1:0]    ptr_lo;
    logic [BYTE_W-1:0]    ext;
    logic [STRETCH_W-1:0] stretch;
    logic                 page_ind;
  } xmp_cfg_t;
endpackage

// File: rtl/xmp_cfg_regs.sv
module xmp_cfg_regs
  import xmp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [SEL_W-1:0]     sel,
  input  logic [BYTE_W-1:0]    wdata,
  output xmp_cfg_t             cfg
);
  logic [NUM_REGS-1:0] wr_en;

  // One decoded enable per register
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign wr_en[i] = we && (sel == SEL_W'(i));
  end

  logic [BYTE_W-1:0]    page_q, page_d;
  logic [BYTE_W-1:0]    hi_q, hi_d;
  logic [BYTE_W-1:0]    lo_q, lo_d;
  logic [BYTE_W-1:0]    ext_q, ext_d;
  logic [STRETCH_W-1:0] st_q, st_d;
  logic                 ctl_q, ctl_d;

  always_comb begin
    page_d = page_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    ext_d  = ext_q;
    st_d   = st_q;
    ctl_d  = ctl_q;
    if (wr_en[SEL_PAGE])    page_d = wdata;
    if (wr_en[SEL_PTR_HI])  hi_d   = wdata;
    if (wr_en[SEL_PTR_LO])  lo_d   = wdata;
    if (wr_en[SEL_EXT])     ext_d  = wdata;
    if (wr_en[SEL_STRETCH]) st_d   = wdata[STRETCH_W-1:0];
    if (wr_en[SEL_CTRL])    ctl_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      ext_q  <= '0;
      st_q   <= '0;
      ctl_q  <= 1'b0;
    end else if (we) begin
      page_q <= page_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      ext_q  <= ext_d;
      st_q   <= st_d;
      ctl_q  <= ctl_d;
    end
  end

  assign cfg.page     = page_q;
  assign cfg.ptr_hi   = hi_q;
  assign cfg.ptr_lo   = lo_q;
  assign cfg.ext      = ext_q;
  assign cfg.stretch  = st_q;
  assign cfg.page_ind = ctl_q;

  AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we) |-> ($stable(page_q) && $stable(st_q) && $stable(ctl_q))) else $error("cfg changed without write"); // R9
endmodule

// File: rtl/xmp_addr_gen.sv
module xmp_addr_gen
  import xmp_pkg::*;
(
  input  xmp_cfg_t          cfg,
  input  logic              indirect,
  input  logic [BYTE_W-1:0] ireg,
  output logic [ADDR_W-1:0] addr
);
  logic [BYTE_W-1:0] top_byte, mid_byte, low_byte;

  always_comb begin
    if (indirect) begin
      top_byte = cfg.page_ind ? cfg.page : '0;
      mid_byte = cfg.ext;
      low_byte = ireg;
    end else begin
      top_byte = cfg.page;
      mid_byte = cfg.ptr_hi;
      low_byte = cfg.ptr_lo;
    end
  end

  assign addr = {top_byte, mid_byte, low_byte};
endmodule

// File: rtl/xmp_seq.sv
module xmp_seq
  import xmp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    addr_in,
  input  logic [DATA_W-1:0]    wdata_in,
  input  logic [STRETCH_W-1:0] stretch_in,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic                 mem_oe,
  output logic                 done,
  output logic [DATA_W-1:0]    rd_data
);
  localparam int MAX_RUN = 1 << STRETCH_W;

  xs_state_t            state_q, state_d;
  logic [STRETCH_W-1:0] cnt_q, cnt_d;
  logic                 wr_q, wr_d;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic [DATA_W-1:0]    wdat_q, wdat_d;
  logic [DATA_W-1:0]    rdat_q, rdat_d;
  logic                 start_en, last_en, cap_en;

  assign start_en = (state_q == XS_IDLE) && req_valid;
  assign last_en  = (state_q == XS_STROBE) && (cnt_q == '0);
  assign cap_en   = last_en && !wr_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    rdat_d  = rdat_q;
    unique case (state_q)
      XS_IDLE: begin
        if (start_en) begin
          state_d = XS_STROBE;
          cnt_d   = stretch_in;
          wr_d    = req_write;
          addr_d  = addr_in;
          wdat_d  = wdata_in;
        end
      end
      XS_STROBE: begin
        if (last_en) begin
          state_d = XS_DONE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
        if (cap_en) rdat_d = mem_rdata;
      end
      XS_DONE:  state_d = XS_IDLE;
      default:  state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (start_en) begin
      addr_q <= addr_d;
      wdat_q <= wdat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdat_q <= '0;
    else if (cap_en) rdat_q <= rdat_d;
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdat_q;
  assign mem_rd    = (state_q == XS_STROBE) && !wr_q;
  assign mem_wr    = (state_q == XS_STROBE) &&  wr_q;
  assign mem_oe    = mem_wr;
  assign done      = (state_q == XS_DONE);
  assign rd_data   = rdat_q;

  // Checker-side run-length counter for strobe width
  logic       stb;
  logic [3:0] run_q;
  assign stb = mem_rd || mem_wr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run_q <= '0;
    else if (stb) run_q <= run_q + 4'd1;
    else          run_q <= '0;
  end

  AST_STROBE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (int'(run_q) < MAX_RUN)) else $error("strobe too long"); // R3
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)) else $error("both strobes"); // R4
  AST_OE_MATCH_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_oe == mem_wr)) else $error("oe mismatch"); // R5
  AST_DONE_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb) |-> done) else $error("no done after strobe"); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R6
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && $past(stb)) |-> ($stable(mem_addr) && $stable(mem_wdata))) else $error("address moved"); // R7
  AST_NO_DIR_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && $past(stb)) |-> ($stable(mem_rd) && $stable(mem_wr))) else $error("direction changed"); // R8
endmodule

// File: rtl/xmem_pager.sv
module xmem_pager
  import xmp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [7:0]        cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_indirect,
  input  logic [7:0]        req_ireg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [23:0]       mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_oe
);
  xmp_cfg_t          cfg;
  logic [ADDR_W-1:0] req_addr;

  xmp_cfg_regs u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  xmp_addr_gen u_addr (
    .cfg      (cfg),
    .indirect (req_indirect),
    .ireg     (req_ireg),
    .addr     (req_addr)
  );

  xmp_seq #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .addr_in    (req_addr),
    .wdata_in   (req_wdata),
    .stretch_in (cfg.stretch),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_oe     (mem_oe),
    .done       (done),
    .rd_data    (rd_data)
  );
endmodule

// File: tb/xmem_pager_tb.sv
`timescale 1ns/1ps
module xmem_pager_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic        req_valid, req_write, req_indirect;
  logic [7:0]  req_ireg, req_wdata;
  logic        done;
  logic [7:0]  rd_data, mem_wdata, mem_rdata;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_wr, mem_oe;

  always #5 clk = ~clk;

  xmem_pager dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_indirect(req_indirect),
    .req_ireg(req_ireg), .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_oe(mem_oe)
  );

  function automatic logic [7:0] mem_fn(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  assign mem_rdata = mem_fn(mem_addr);

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // Behavioural reference model
  int          m_phase = 0;   // 0 idle, 1 strobe, 2 done
  int          m_left  = 0;
  bit          m_wr    = 0;
  bit          m_ind   = 0;
  logic [23:0] m_addr  = '0;
  logic [7:0]  m_wd    = '0;
  logic [7:0]  m_cap   = '0;
  logic [7:0]  r_page = '0, r_hi = '0, r_lo = '0, r_ext = '0;
  int          r_st = 0;
  bit          r_ctl = 0;
  int          wr_starts = 0;
  bit          prev_wr = 0;

  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_wr = 0; m_cap = '0;
      r_page = '0; r_hi = '0; r_lo = '0; r_ext = '0; r_st = 0; r_ctl = 0;
    end else begin
      case (m_phase)
        0: if (req_valid) begin
             m_phase = 1;
             m_left  = r_st;
             m_wr    = req_write;
             m_ind   = req_indirect;
             m_wd    = req_wdata;
             if (req_indirect) m_addr = {(r_ctl ? r_page : 8'h00), r_ext, req_ireg};
             else              m_addr = {r_page, r_hi, r_lo};
           end
        1: if (m_left == 0) begin
             if (!m_wr) m_cap = mem_fn(m_addr);
             m_phase = 2;
           end else m_left--;
        default: m_phase = 0;
      endcase
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: r_page = cfg_wdata;
          3'd1: r_lo   = cfg_wdata;
          3'd2: r_hi   = cfg_wdata;
          3'd3: r_ext  = cfg_wdata;
          3'd4: r_st   = int'(cfg_wdata[2:0]);
          3'd5: r_ctl  = cfg_wdata[0];
          default: ;
        endcase
      end
    end
    #2;
    if (!rst_n) begin
      check("R9 strobes in reset", {mem_rd, mem_wr, mem_oe, done}, 0);
      check("R9 rd_data in reset", rd_data, 0);
    end else begin
      check("R4 mem_rd", mem_rd, (m_phase == 1) && !m_wr);
      check("R4 mem_wr", mem_wr, (m_phase == 1) && m_wr);
      check("R5 mem_oe", mem_oe, (m_phase == 1) && m_wr);
      check("R6 done", done, m_phase == 2);
      check("R6 rd_data", rd_data, m_cap);
      if (m_phase == 1) begin
        check(m_ind ? "R2 indirect addr" : "R1 pointer addr", mem_addr, m_addr);
        if (m_wr) check("R7 write data", mem_wdata, m_wd);
      end
      if (mem_wr && !prev_wr) wr_starts++;
      prev_wr = mem_wr;
    end
  end

  task automatic cfg_write(input logic [2:0] s, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input bit w, input bit ind, input logic [7:0] ir, input logic [7:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_indirect = ind; req_ireg = ir; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (11) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    req_valid = 0; req_write = 0; req_indirect = 0; req_ireg = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1, R3: pointer read, stretch 0
    cfg_write(3'd0, 8'h12); cfg_write(3'd2, 8'h34); cfg_write(3'd1, 8'h56);
    access(0, 0, 8'h00, 8'h00);
    // R3: stretch 7 write
    cfg_write(3'd4, 8'hFF);
    access(1, 0, 8'h00, 8'hC3);
    // R1: page swap
    cfg_write(3'd0, 8'hE7); cfg_write(3'd4, 8'h02);
    access(0, 0, 8'h00, 8'h00);
    // R2: indirect with page select off and on
    cfg_write(3'd3, 8'h9A);
    access(0, 1, 8'h4B, 8'h00);
    cfg_write(3'd5, 8'h01);
    access(1, 1, 8'hF0, 8'h3C);
    access(0, 1, 8'h11, 8'h00);
    // R9: unused selects ignored
    cfg_write(3'd6, 8'hAA); cfg_write(3'd7, 8'h55);
    access(0, 0, 8'h00, 8'h00);

    // R7: register writes during an access
    cfg_write(3'd4, 8'h05);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_indirect = 0;
    @(negedge clk);
    req_valid = 0; cfg_we = 1; cfg_sel = 3'd4; cfg_wdata = 8'h00;
    @(negedge clk);
    cfg_sel = 3'd1; cfg_wdata = 8'h77;
    @(negedge clk);
    cfg_we = 0;
    repeat (10) @(negedge clk);

    // R8: request held through strobe and done is ignored
    cfg_write(3'd4, 8'h03);
    wr_starts = 0;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_indirect = 0; req_wdata = 8'h81;
    @(negedge clk);
    req_wdata = 8'h18; req_write = 0;
    repeat (4) @(negedge clk);
    req_valid = 0;
    repeat (10) @(negedge clk);
    check("R8 single write strobe", wr_starts, 1);

    // R9: reset mid-access clears everything
    @(negedge clk);
    req_valid = 1; req_write = 1;
    @(negedge clk);
    req_valid = 0;
    rst_n = 0;
    @(negedge clk);
    check("R9 strobes cleared", {mem_rd, mem_wr, mem_oe, done}, 0);
    rst_n = 1;
    access(0, 0, 8'h00, 8'h00);
    check("R9 regs cleared (addr 0)", mem_addr, 24'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule